// File: doc/BRIEF.md
# Three-Tap Pre-Emphasis Cursor Aligner

This block feeds a segmented three-tap transmit driver. It runs at the half-rate clock. In every cycle it takes one even-phase bit and one odd-phase bit, which together carry two consecutive bits of the full-rate serial stream, with the even bit first. For each of the two phases it produces three bits: a main-cursor bit, a pre-cursor bit (the bit sent after the main one) and a post-cursor bit (the bit sent before it). These three bits are aligned so that the driver can sum its taps at the same instant.

It also turns three programmable segment counts into thermometer enable vectors. The pre tap has 3 segments, the main tap 15 and the post tap 7. These enables set how strongly each tap drives, so the de-emphasis amplitude can be matched to the channel loss. The pre and post data bits are normally sent inverted, so that any enabled side segment subtracts from the main swing. A configuration bit turns this inversion off for testing. A second configuration bit turns off the side taps entirely.

All configuration is held in registers. They load only in a cycle where the write strobe is high.

Top module: `tapgen_top`

## Requirements
- R1: A synchronous active-high reset clears the data pipeline and the configuration registers. After reset every main output is 0, every pre and post output is 1 (a zero cursor, inverted), and every segment enable is 0.
- R2: The even-phase main output equals the even input presented two half-rate cycles earlier.
- R3: For the even phase, the pre output is derived from the odd bit of the same pair and the post output from the odd bit of the previous pair.
- R4: For the odd phase, the main output is the odd input from two cycles earlier. The pre output is derived from the even bit of the next pair, which is the even input one cycle earlier. The post output is derived from the even bit of the same pair.
- R5: When the bypass configuration bit is 0, the pre and post outputs of both phases are the complement of the cursor bit. When it is 1, they carry the cursor bit unchanged. Main outputs are never inverted.
- R6: A segment count n (2 bits for pre, 4 bits for main, 3 bits for post) enables exactly the segments with index below n, starting from bit 0. A count at or above the bank size turns on every segment of that bank.
- R7: When the emphasis-enable configuration bit is 0, the pre and post enables are all zero whatever their counts are, while the main enables still follow the main count.
- R8: Configuration inputs are captured only on a clock edge with the write strobe at 1. Changes on these inputs while the strobe is 0 leave the segment enables and the inversion unchanged. A write takes effect on the outputs right after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| d_even | input | 1 | Even-phase data bit (earlier bit of the pair) |
| d_odd | input | 1 | Odd-phase data bit (later bit of the pair) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pre_cnt | input | 2 | Pre tap segment count |
| cfg_main_cnt | input | 4 | Main tap segment count |
| cfg_post_cnt | input | 3 | Post tap segment count |
| cfg_emph_en | input | 1 | Enable side taps |
| cfg_inv_bypass | input | 1 | Send side cursor bits uninverted |
| ev_pre | output | 1 | Even phase pre-cursor bit |
| ev_main | output | 1 | Even phase main-cursor bit |
| ev_post | output | 1 | Even phase post-cursor bit |
| od_pre | output | 1 | Odd phase pre-cursor bit |
| od_main | output | 1 | Odd phase main-cursor bit |
| od_post | output | 1 | Odd phase post-cursor bit |
| seg_pre_en | output | 3 | Pre tap segment enables |
| seg_main_en | output | 15 | Main tap segment enables |
| seg_post_en | output | 7 | Post tap segment enables |

## Verification
The bench targets the places where the two phases meet. The odd-phase pre bit comes from the next pair's even input, and the even-phase post bit comes from the previous pair's odd input. A design that shifts either one by a cycle, or takes it from the wrong phase, produces wrong side taps on alternating and random data even though the main taps still look right. Count extremes (zero and full bank) catch thermometer decoders that are off by one. Toggling the emphasis enable and the bypass bit, and changing the configuration inputs without the strobe, catches side enables that leak through, inversion applied to the main tap, and registers that load without a write.

// File: rtl/tapgen_pkg.sv
`timescale 1ns/1ps
package tapgen_pkg;
    localparam int PRE_SEGS_D  = 3;
    localparam int MAIN_SEGS_D = 15;
    localparam int POST_SEGS_D = 7;

    typedef struct packed {
        logic pre;
        logic main;
        logic post;
    } tap_t;

    typedef struct packed {
        logic emph_en;
        logic inv_bypass;
    } ctl_t;

    function automatic logic side_bit(input logic cursor, input ctl_t c);
        return cursor ^ ~c.inv_bypass;
    endfunction
endpackage

// File: rtl/tapgen_cfg.sv
`timescale 1ns/1ps
module tapgen_cfg
    import tapgen_pkg::*;
#(
    parameter int PRE_CW  = 2,
    parameter int MAIN_CW = 4,
    parameter int POST_CW = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [PRE_CW-1:0]  pre_in,
    input  logic [MAIN_CW-1:0] main_in,
    input  logic [POST_CW-1:0] post_in,
    input  ctl_t               ctl_in,
    output logic [PRE_CW-1:0]  pre_q,
    output logic [MAIN_CW-1:0] main_q,
    output logic [POST_CW-1:0] post_q,
    output ctl_t               ctl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            main_q <= '0;
            post_q <= '0;
            ctl_q  <= '0;
        end else if (wr) begin
            pre_q  <= pre_in;
            main_q <= main_in;
            post_q <= post_in;
            ctl_q  <= ctl_in;
        end
    end

    // R8: registers hold without a write strobe
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr) && !$past(rst)) |->
            ($stable(pre_q) && $stable(main_q) && $stable(post_q) && $stable(ctl_q)));
endmodule

// File: rtl/tapgen_align.sv
`timescale 1ns/1ps
module tapgen_align
    import tapgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic d_even,
    input  logic d_odd,
    output tap_t ev_q,
    output tap_t od_q
);
    logic even_s1, odd_s1, odd_s2;
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            even_s1 <= 1'b0;
            odd_s1  <= 1'b0;
            odd_s2  <= 1'b0;
            ev_q    <= '0;
            od_q    <= '0;
        end else begin
            even_s1   <= d_even;
            odd_s1    <= d_odd;
            odd_s2    <= odd_s1;
            ev_q.main <= even_s1;
            ev_q.pre  <= odd_s1;
            ev_q.post <= odd_s2;
            od_q.main <= odd_s1;
            od_q.pre  <= d_even;
            od_q.post <= even_s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r2_even_main: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (ev_q.main == $past(d_even, 2)));

    a_r3_even_pre: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (ev_q.pre == $past(d_odd, 2)));

    a_r3_even_post: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (ev_q.post == $past(d_odd, 3)));

    a_r4_odd_taps: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (od_q.pre == $past(d_even, 1) &&
                           od_q.post == $past(d_even, 2) &&
                           od_q.main == $past(d_odd, 2)));
endmodule

// File: rtl/tapgen_seg.sv
`timescale 1ns/1ps
module tapgen_seg #(
    parameter int SEGS = 7,
    parameter int CW   = $clog2(SEGS + 1)
) (
    input  logic          enable,
    input  logic [CW-1:0] count,
    output logic [SEGS-1:0] en
);
    for (genvar i = 0; i < SEGS; i++) begin : g_seg
        assign en[i] = enable && (32'(count) > 32'(i));
    end
endmodule

// File: rtl/tapgen_top.sv
`timescale 1ns/1ps
module tapgen_top
    import tapgen_pkg::*;
#(
    parameter int PRE_SEGS  = PRE_SEGS_D,
    parameter int MAIN_SEGS = MAIN_SEGS_D,
    parameter int POST_SEGS = POST_SEGS_D,
    localparam int PRE_CW   = $clog2(PRE_SEGS + 1),
    localparam int MAIN_CW  = $clog2(MAIN_SEGS + 1),
    localparam int POST_CW  = $clog2(POST_SEGS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 d_even,
    input  logic                 d_odd,
    input  logic                 cfg_wr,
    input  logic [PRE_CW-1:0]    cfg_pre_cnt,
    input  logic [MAIN_CW-1:0]   cfg_main_cnt,
    input  logic [POST_CW-1:0]   cfg_post_cnt,
    input  logic                 cfg_emph_en,
    input  logic                 cfg_inv_bypass,
    output logic                 ev_pre,
    output logic                 ev_main,
    output logic                 ev_post,
    output logic                 od_pre,
    output logic                 od_main,
    output logic                 od_post,
    output logic [PRE_SEGS-1:0]  seg_pre_en,
    output logic [MAIN_SEGS-1:0] seg_main_en,
    output logic [POST_SEGS-1:0] seg_post_en
);
    logic [PRE_CW-1:0]  pre_cnt;
    logic [MAIN_CW-1:0] main_cnt;
    logic [POST_CW-1:0] post_cnt;
    ctl_t ctl_in, ctl;
    tap_t ev_raw, od_raw;

    assign ctl_in = '{emph_en: cfg_emph_en, inv_bypass: cfg_inv_bypass};

    tapgen_cfg #(.PRE_CW(PRE_CW), .MAIN_CW(MAIN_CW), .POST_CW(POST_CW)) u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_wr),
        .pre_in(cfg_pre_cnt), .main_in(cfg_main_cnt), .post_in(cfg_post_cnt),
        .ctl_in(ctl_in),
        .pre_q(pre_cnt), .main_q(main_cnt), .post_q(post_cnt), .ctl_q(ctl)
    );

    tapgen_align u_align (
        .clk(clk), .rst(rst), .d_even(d_even), .d_odd(d_odd),
        .ev_q(ev_raw), .od_q(od_raw)
    );

    tapgen_seg #(.SEGS(PRE_SEGS), .CW(PRE_CW)) u_seg_pre (
        .enable(ctl.emph_en), .count(pre_cnt), .en(seg_pre_en));
    tapgen_seg #(.SEGS(MAIN_SEGS), .CW(MAIN_CW)) u_seg_main (
        .enable(1'b1), .count(main_cnt), .en(seg_main_en));
    tapgen_seg #(.SEGS(POST_SEGS), .CW(POST_CW)) u_seg_post (
        .enable(ctl.emph_en), .count(post_cnt), .en(seg_post_en));

    assign ev_main = ev_raw.main;
    assign od_main = od_raw.main;
    assign ev_pre  = side_bit(ev_raw.pre,  ctl);
    assign ev_post = side_bit(ev_raw.post, ctl);
    assign od_pre  = side_bit(od_raw.pre,  ctl);
    assign od_post = side_bit(od_raw.post, ctl);

    a_r6_main_count: assert property (@(posedge clk) disable iff (rst)
        $countones(seg_main_en) ==
            ((32'(main_cnt) > MAIN_SEGS) ? MAIN_SEGS : 32'(main_cnt)));

    a_r6_low_first: assert property (@(posedge clk) disable iff (rst)
        (main_cnt != '0) |-> seg_main_en[0]);

    a_r7_side_off: assert property (@(posedge clk) disable iff (rst)
        !ctl.emph_en |-> (seg_pre_en == '0 && seg_post_en == '0));
endmodule

// File: tb/tb_tapgen_top.sv
`timescale 1ns/1ps
module tb_tapgen_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic d_even = 1'b0, d_odd = 1'b0;
    logic cfg_wr = 1'b0;
    logic [1:0] cfg_pre_cnt = '0;
    logic [3:0] cfg_main_cnt = '0;
    logic [2:0] cfg_post_cnt = '0;
    logic cfg_emph_en = 1'b0, cfg_inv_bypass = 1'b0;
    logic ev_pre, ev_main, ev_post, od_pre, od_main, od_post;
    logic [2:0]  seg_pre_en;
    logic [14:0] seg_main_en;
    logic [6:0]  seg_post_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic he [0:2047];
    logic ho [0:2047];
    int j = 2;
    int m_pre = 0, m_main = 0, m_post = 0;
    bit m_emph = 0, m_byp = 0;

    always #4 clk = ~clk;

    tapgen_top dut (.*);

    function automatic logic [31:0] therm(input int n, input int segs);
        logic [31:0] v = '0;
        for (int i = 0; i < segs; i++) v[i] = (i < n);
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (pair %0d)", req, act, exp, j);
        end
    endtask

    task automatic check_all();
        logic inv = !m_byp;
        chk("R2 even main", 32'(ev_main), 32'(he[j-1]));
        chk("R3 even pre",  32'(ev_pre),  32'(ho[j-1] ^ inv));
        chk("R3 even post", 32'(ev_post), 32'(ho[j-2] ^ inv));
        chk("R4 odd main",  32'(od_main), 32'(ho[j-1]));
        chk("R4 odd pre",   32'(od_pre),  32'(he[j] ^ inv));
        chk("R4 odd post",  32'(od_post), 32'(he[j-1] ^ inv));
        chk("R6 main seg",  32'(seg_main_en), therm(m_main, 15));
        chk("R6/R7 pre seg",  32'(seg_pre_en),  m_emph ? therm(m_pre, 3) : 32'd0);
        chk("R6/R7 post seg", 32'(seg_post_en), m_emph ? therm(m_post, 7) : 32'd0);
    endtask

    // one half-rate cycle; inputs are changed at the falling edge
    task automatic step(input logic e, input logic o, input bit wr);
        d_even = e; d_odd = o; cfg_wr = wr;
        he[j] = e; ho[j] = o;
        @(posedge clk);
        if (wr) begin
            m_pre = cfg_pre_cnt; m_main = cfg_main_cnt; m_post = cfg_post_cnt;
            m_emph = cfg_emph_en; m_byp = cfg_inv_bypass;
        end
        @(negedge clk);
        check_all();
        cfg_wr = 1'b0;
        j++;
    endtask

    task automatic set_cfg(input int p, input int mn, input int ps, input bit em, input bit by);
        cfg_pre_cnt = 2'(p); cfg_main_cnt = 4'(mn); cfg_post_cnt = 3'(ps);
        cfg_emph_en = em; cfg_inv_bypass = by;
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin he[i] = 1'b0; ho[i] = 1'b0; end
        void'($urandom(32'd20240311));
        // R1: reset state
        d_even = 1'b1; d_odd = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 main", {30'd0, ev_main, od_main}, 32'd0);
        chk("R1 side", {28'd0, ev_pre, ev_post, od_pre, od_post}, 32'hf);
        chk("R1 seg",  {7'd0, seg_pre_en, seg_main_en, seg_post_en}, 32'd0);
        rst = 1'b0;
        d_even = 1'b0; d_odd = 1'b0;

        // R6, R7: directed config, including zero and full banks
        set_cfg(2, 9, 5, 1, 0); step(1, 1, 1);
        step(1, 1, 0); step(1, 1, 0);
        step(0, 1, 0); step(1, 0, 0); step(0, 1, 0); step(1, 0, 0);
        set_cfg(3, 15, 7, 1, 0); step(0, 0, 1);
        set_cfg(0, 0, 0, 1, 0);  step(1, 0, 1);
        set_cfg(3, 15, 7, 0, 0); step(0, 1, 1);   // R7: side taps forced off
        set_cfg(1, 1, 1, 1, 1);  step(1, 1, 1);   // R5: bypass on
        step(0, 1, 0); step(1, 0, 0);
        // R8: change inputs without strobe; model stays unchanged
        set_cfg(0, 4, 6, 0, 0);  step(0, 0, 0); step(1, 1, 0);
        set_cfg(2, 6, 3, 1, 0);  step(1, 0, 1);

        // random phase
        for (int n = 0; n < 1500; n++) begin
            bit wr = ($urandom % 16) == 0;
            if (($urandom % 4) == 0)
                set_cfg($urandom % 4, $urandom % 16, $urandom % 8,
                        1'($urandom), 1'($urandom));
            step(1'($urandom), 1'($urandom), wr);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule